// File: doc/BRIEF.md
# Service Queue Ticket Caller

This block drives a counter-style queue display for a service hall with several service windows. Each window has a push button. When a clerk presses a button, the shared ticket number on display goes up by one. The block also remembers which window made that call, so the display shows which window the customer holding the new ticket should go to.

The buttons are mechanical and active-low. Each button passes through a two-flop synchronizer and then a counting debouncer. A press counts only on the falling edge of the debounced level. All windows feed one count event. The ticket number is kept as two BCD digits, from 00 to 99. The units digit, the tens digit and the window number are each also given as a seven-segment pattern. The system reset doubles as the operator's clear button.

Top module: `queue_caller`

## Requirements
- R1: One recognised press on any window button increases the ticket number (10*tens + units) by exactly one. With no press, the ticket number does not change.
- R2: Buttons are active-low. A press is recognised on the debounced high-to-low transition. Holding a button low gives no further increments, and releasing it gives none.
- R3: A button level that stays for fewer than DEBOUNCE_CYCLES consecutive cycles after the two-flop synchronizer is ignored. A bouncing press made of such short pulses followed by a steady low level gives a single increment.
- R4: The units digit is BCD from 0 to 9. On an increment it returns to 0 in place of becoming binary 1010, which is detected as bit 3 and bit 1 both high.
- R5: The tens digit advances only on the increment that wraps the units digit from 9 to 0. Ticket 99 followed by one increment gives 00, with no carry out.
- R6: The window register holds the number (1 to NUM_WINDOWS) of the window that made the most recent call. It holds this value after the button is released and reads 0 after reset.
- R7: When presses on several windows are recognised in the same cycle, only one increment occurs and the lowest-numbered window is recorded.
- R8: A low level on rst_n, sampled on the clock edge, clears both digits and the window register to 0.
- R9: Each segment output is 7 bits {g,f,e,d,c,b,a}, active-high. The codes for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). Any value above 9 gives 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset and clear button |
| win_btn_n | input | NUM_WINDOWS | Active-low window buttons; bit i is window i+1 |
| units_bcd | output | 4 | Units digit of the ticket number, BCD |
| tens_bcd | output | 4 | Tens digit of the ticket number, BCD |
| window_num | output | $clog2(NUM_WINDOWS+1) | Window of the most recent call, 0 after reset |
| units_seg | output | 7 | Units digit as a segment pattern |
| tens_seg | output | 7 | Tens digit as a segment pattern |
| window_seg | output | 7 | Window number as a segment pattern |

## Verification
On every cycle, the assertions check the following:
- Each digit stays in BCD range.
- A digit steps by one when it is told to, and holds otherwise.
- A digit wraps from 9 to 0 at the 1010 point.
- A carry out of the tens digit leaves the display at 00.
- A debounced press lasts a single cycle.
- The window register holds between calls and gives priority to window 1.

Some behaviour only the bench scenarios can show. These are the end-to-end effect of contact bounce and held buttons on the count, the full 0-to-99 sweep with its wrap, the simultaneous-press case and the segment codes seen at the outputs.

// File: rtl/qc_pkg.sv
// qc_pkg: shared constants and the BCD to seven-segment mapping.
// Assumes segment order {g,f,e,d,c,b,a}, active-high.
package qc_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    typedef logic [DIGIT_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0]   seg_t;

    // Map one BCD value to its segment pattern; non-decimal values blank.
    function automatic seg_t bcd_to_seg(input bcd_t val);
        seg_t s;
        case (val)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/qc_debounce.sv
// qc_debounce: synchronises one active-low button and filters contact bounce.
// A new level is accepted once it has been stable for DEBOUNCE_CYCLES
// cycles after the two-flop synchronizer. press_o pulses for one cycle
// when the accepted level goes from high to low.
// Assumes DEBOUNCE_CYCLES >= 1 and that the button idles high.
module qc_debounce #(
    parameter int DEBOUNCE_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n_i,
    output logic press_o
);

    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEBOUNCE_CYCLES - 1);

    logic             sync1_q;
    logic             sync2_q;
    logic             level_q;
    logic [CNT_W-1:0] cnt_q;
    logic             press_q;

    // Synchronise the raw input, time its stability and accept new levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            level_q <= 1'b1;
            cnt_q   <= '0;
            press_q <= 1'b0;
        end else begin
            sync1_q <= btn_n_i;
            sync2_q <= sync1_q;
            press_q <= 1'b0;
            if (sync2_q == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == LIMIT) begin
                level_q <= sync2_q;
                cnt_q   <= '0;
                press_q <= !sync2_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign press_o = press_q;

    AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        press_q |=> !press_q); // R2

    AST_PRESS_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        press_q |-> !level_q); // R2

endmodule

// File: rtl/qc_bcd_digit.sv
// qc_bcd_digit: one decade counter stage of the ticket number.
// Steps by one when inc_i is high. It clears when the next value would
// reach binary 1010, found from bits 3 and 1. carry_o is high in the
// cycle that wraps.
// Assumes the value only ever enters through reset or this counter.
module qc_bcd_digit
    import qc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    output bcd_t digit_o,
    output logic carry_o
);

    bcd_t digit_q;
    bcd_t next_val;
    logic hit_ten;

    // Form the incremented value and spot the 1010 pattern.
    always_comb begin
        next_val = digit_q + 4'd1;
        hit_ten  = next_val[3] && next_val[1];
    end

    // Hold, step or wrap the digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_q <= '0;
        end else if (inc_i) begin
            digit_q <= hit_ten ? '0 : next_val;
        end
    end

    assign digit_o = digit_q;
    assign carry_o = inc_i && hit_ten;

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        digit_q <= 4'd9); // R4

    AST_DIGIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && digit_q != 4'd9) |=> digit_q == 4'($past(digit_q) + 4'd1)); // R4

    AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && digit_q == 4'd9) |=> digit_q == 4'd0); // R5

    AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(digit_q)); // R1

endmodule

// File: rtl/qc_seg_decode.sv
// qc_seg_decode: combinational BCD to seven-segment converter.
// Assumes active-high segments in the order {g,f,e,d,c,b,a}.
module qc_seg_decode
    import qc_pkg::*;
(
    input  bcd_t val_i,
    output seg_t seg_o
);

    // Look up the pattern for the value.
    always_comb begin
        seg_o = bcd_to_seg(val_i);
    end

endmodule

// File: rtl/queue_caller.sv
// queue_caller: top of the queue ticket caller.
// Debounces each window button and merges the presses into one count
// event. It keeps a two-digit BCD ticket number and latches the
// lowest-numbered calling window. All three values are also decoded to
// segment patterns.
// Assumes NUM_WINDOWS <= 9, so that the window number fits one display digit.
module queue_caller
    import qc_pkg::*;
#(
    parameter int NUM_WINDOWS     = 3,
    parameter int DEBOUNCE_CYCLES = 50000,
    localparam int WIN_W          = $clog2(NUM_WINDOWS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_WINDOWS-1:0] win_btn_n,
    output logic [3:0]             units_bcd,
    output logic [3:0]             tens_bcd,
    output logic [WIN_W-1:0]       window_num,
    output logic [6:0]             units_seg,
    output logic [6:0]             tens_seg,
    output logic [6:0]             window_seg
);

    logic [NUM_WINDOWS-1:0] press;
    logic                   any_press;
    logic [WIN_W-1:0]       caller;
    logic [WIN_W-1:0]       window_q;
    logic                   units_carry;
    logic                   tens_carry;

    // One synchroniser and debouncer per window button.
    for (genvar g = 0; g < NUM_WINDOWS; g++) begin : g_btn
        qc_debounce #(
            .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
        ) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .btn_n_i (win_btn_n[g]),
            .press_o (press[g])
        );
    end

    // Merge presses and pick the lowest-numbered calling window.
    always_comb begin
        any_press = |press;
        caller    = '0;
        for (int i = NUM_WINDOWS - 1; i >= 0; i--) begin
            if (press[i]) caller = WIN_W'(i + 1);
        end
    end

    // Latch the window that made the most recent call.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window_q <= '0;
        end else if (any_press) begin
            window_q <= caller;
        end
    end

    qc_bcd_digit u_units (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (any_press),
        .digit_o (units_bcd),
        .carry_o (units_carry)
    );

    qc_bcd_digit u_tens (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (units_carry),
        .digit_o (tens_bcd),
        .carry_o (tens_carry)
    );

    assign window_num = window_q;

    qc_seg_decode u_seg_units  (.val_i(units_bcd),      .seg_o(units_seg));
    qc_seg_decode u_seg_tens   (.val_i(tens_bcd),       .seg_o(tens_seg));
    qc_seg_decode u_seg_window (.val_i(4'(window_q)),   .seg_o(window_seg));

    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        window_q <= WIN_W'(NUM_WINDOWS)); // R6

    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_press |=> $stable(window_q)); // R6

    AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        press[0] |=> window_q == WIN_W'(1)); // R7

    AST_NO_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        tens_carry |=> (units_bcd == 4'd0 && tens_bcd == 4'd0)); // R5

endmodule

// File: tb/queue_caller_test.sv
// queue_caller_test: sweeps the ticket through more than one full wrap,
// rotating windows, and covers bounce, hold, simultaneous presses and
// reset. Expected values are computed arithmetically.
module queue_caller_test;

    localparam int NW  = 3;
    localparam int DEB = 4;
    localparam int SETTLE = DEB + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] win_btn_n = '1;
    logic [3:0]    units_bcd;
    logic [3:0]    tens_bcd;
    logic [1:0]    window_num;
    logic [6:0]    units_seg;
    logic [6:0]    tens_seg;
    logic [6:0]    window_seg;

    int checks = 0;
    int failures = 0;
    int exp_ticket = 0;
    int exp_win = 0;
    int cycles = 0;

    queue_caller #(
        .NUM_WINDOWS     (NW),
        .DEBOUNCE_CYCLES (DEB)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_btn_n  (win_btn_n),
        .units_bcd  (units_bcd),
        .tens_bcd   (tens_bcd),
        .window_num (window_num),
        .units_seg  (units_seg),
        .tens_seg   (tens_seg),
        .window_seg (window_seg)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [6:0] seg_of(input int v);
        case (v)
            0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;
            3: return 7'h4F;  4: return 7'h66;  5: return 7'h6D;
            6: return 7'h7D;  7: return 7'h07;  8: return 7'h7F;
            9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Compare every output with the bench model.
    task automatic check_all(input string req);
        check({req, " units"}, int'(units_bcd), exp_ticket % 10);
        check({req, " tens"}, int'(tens_bcd), exp_ticket / 10);
        check({req, " window"}, int'(window_num), exp_win);
        check({req, " R9 units_seg"}, int'(units_seg), int'(seg_of(exp_ticket % 10)));
        check({req, " R9 tens_seg"}, int'(tens_seg), int'(seg_of(exp_ticket / 10)));
        check({req, " R9 window_seg"}, int'(window_seg), int'(seg_of(exp_win)));
    endtask

    // Clean press and release on one window.
    task automatic press(input int idx, input string req);
        @(negedge clk);
        win_btn_n[idx] = 1'b0;
        wait_cycles(SETTLE);
        exp_ticket = (exp_ticket + 1) % 100;
        exp_win = idx + 1;
        check_all(req);
        win_btn_n[idx] = 1'b1;
        wait_cycles(SETTLE);
        check_all("R2 release");
    endtask

    initial begin
        wait_cycles(3);
        check_all("R8 reset state");
        rst_n = 1'b1;
        wait_cycles(2);
        check_all("R6 idle after reset");

        // R1 R4 R5: sweep past a full wrap while rotating windows.
        for (int n = 0; n < 103; n++) begin
            press(n % NW, "R1 R4 R5 sweep");
        end

        // R3: short glitch alone is ignored.
        @(negedge clk);
        win_btn_n[1] = 1'b0;
        wait_cycles(DEB - 2);
        win_btn_n[1] = 1'b1;
        wait_cycles(SETTLE);
        check_all("R3 glitch");

        // R3: bouncing press then steady low counts once.
        for (int b = 0; b < 5; b++) begin
            win_btn_n[2] = 1'b0;
            wait_cycles(2);
            win_btn_n[2] = 1'b1;
            wait_cycles(2);
        end
        win_btn_n[2] = 1'b0;
        wait_cycles(SETTLE);
        exp_ticket = (exp_ticket + 1) % 100;
        exp_win = 3;
        check_all("R3 bounce press");

        // R2: holding gives no further increments.
        wait_cycles(10 * SETTLE);
        check_all("R2 hold");
        for (int b = 0; b < 4; b++) begin
            win_btn_n[2] = 1'b1;
            wait_cycles(2);
            win_btn_n[2] = 1'b0;
            wait_cycles(2);
        end
        win_btn_n[2] = 1'b1;
        wait_cycles(SETTLE);
        check_all("R2 R3 bouncing release");

        // R7: windows 2 and 3 together, then all three.
        win_btn_n = 3'b001;
        wait_cycles(SETTLE);
        exp_ticket = (exp_ticket + 1) % 100;
        exp_win = 2;
        check_all("R7 pair");
        win_btn_n = 3'b111;
        wait_cycles(SETTLE);
        win_btn_n = 3'b000;
        wait_cycles(SETTLE);
        exp_ticket = (exp_ticket + 1) % 100;
        exp_win = 1;
        check_all("R7 all");
        win_btn_n = 3'b111;
        wait_cycles(SETTLE);

        // R6: a later single call replaces the window.
        press(2, "R6 later call");

        // R8: reset clears the digits and the window.
        rst_n = 1'b0;
        wait_cycles(2);
        exp_ticket = 0;
        exp_win = 0;
        check_all("R8 clear");
        rst_n = 1'b1;
        wait_cycles(2);
        press(1, "R1 after clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule